// File: doc/BRIEF.md
# Trace Permission and Timestamp Selector

This unit sits beside an instruction-trace generator and answers two questions every cycle. The first is whether trace output is permitted at the privilege level the processor is running at. The second is which 64-bit time value is stamped into the trace stream. Permission is combinational, so the generator can gate the current cycle. The timestamp is registered: the counter is sampled on one edge and the stamp is presented after that edge, together with a valid flag.

Two sets of controls feed the unit. The level-1 filter controls are an enable for level 0, an enable for level 1 and a 2-bit timestamp code. The higher-level context is a global self-hosted trace enable, flags that say whether level 2 exists and is active, a trap-general routing bit, a level-2 permission input and a level-2 timestamp code. A nonzero level-2 timestamp code replaces the level-1 code when level 2 exists. Timestamp code 3 means the physical counter as it is. Code 1 means a virtual time, which is the physical counter minus an offset. Codes 0 and 2 mean that no stamp is produced.

Top module: `trace_gate_ts`

## Requirements
- R1: At privilege levels 2 and 3, trace_allowed is 0 whatever the enable inputs are.
- R2: With selfhost_en at 0, trace_allowed is 0 at every level. ts_valid is 0 on the cycle after, because the effective timestamp code is then treated as 0.
- R3: At level 1 with selfhost_en at 1, trace_allowed equals l1_en_lvl1.
- R4: At level 0 with selfhost_en at 1, trace_allowed equals l1_en_lvl0 unless lvl2_active and tge_route are both 1. This includes the case where tge_route is 1 but lvl2_active is 0.
- R5: At level 0 with selfhost_en, lvl2_active and tge_route all at 1, trace_allowed equals lvl2_trace_en and l1_en_lvl0 has no effect.
- R6: When the effective code is 2'b11, after the next rising edge ts_valid is 1 and ts_value equals the phys_count sampled at that edge.
- R7: When the effective code is 2'b01, after the next edge ts_valid is 1 and ts_value equals phys_count minus virt_offset modulo 2^64, wrapping when the offset is larger than the count.
- R8: When lvl2_present is 1 and lvl2_ts_code is nonzero, the level-2 code is the effective code. Otherwise l1_ts_code is the effective code, and lvl2_ts_code is ignored when lvl2_present is 0.
- R9: An effective code of 2'b00 or 2'b10 makes ts_valid 0 after the next edge, and ts_value keeps its previous value.
- R10: While rst_n is low, ts_valid is 0 and ts_value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| selfhost_en | input | 1 | Global self-hosted trace enable |
| l1_en_lvl0 | input | 1 | Level-1 filter: trace enable for level 0 |
| l1_en_lvl1 | input | 1 | Level-1 filter: trace enable for level 1 |
| l1_ts_code | input | 2 | Level-1 filter timestamp code |
| lvl2_present | input | 1 | Level 2 is implemented |
| lvl2_active | input | 1 | Level 2 is enabled in the current security state |
| tge_route | input | 1 | Trap-general-exceptions routing bit |
| lvl2_trace_en | input | 1 | Level-0 permission used when routing is in force |
| lvl2_ts_code | input | 2 | Level-2 timestamp code (overrides when nonzero) |
| phys_count | input | 64 | Physical counter |
| virt_offset | input | 64 | Virtual counter offset |
| trace_allowed | output | 1 | Trace is permitted this cycle |
| ts_value | output | 64 | Registered timestamp |
| ts_valid | output | 1 | ts_value was updated at the last edge |

## Verification
The assertions check on every cycle the permission masks: levels 2 and 3, the global disable, level 1 following its enable and the routed level-0 case. They also check that a level-2 code overrides the level-1 code when it should, that a stamp one edge later matches the sampled counter or its difference, and that the stamp is stable whenever the valid flag is low. Some behaviour only the bench scenarios can show. These are the wrap of the subtraction for a chosen large offset, the non-routed level-0 case where the trap bit is set but level 2 is inactive, that the level-2 code is ignored without level 2, and the held value across a run of reserved codes after a known stamp.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;

  typedef enum logic [1:0] {
    TS_NONE = 2'b00,
    TS_VIRT = 2'b01,
    TS_RSVD = 2'b10,
    TS_PHYS = 2'b11
  } ts_code_e;

  typedef enum logic [1:0] {
    PL_0 = 2'd0,
    PL_1 = 2'd1,
    PL_2 = 2'd2,
    PL_3 = 2'd3
  } priv_lvl_e;

  // A code yields a stamp only when it names one of the two sources.
  function automatic logic ts_code_usable(ts_code_e c);
    return (c == TS_VIRT) || (c == TS_PHYS);
  endfunction

endpackage

// File: rtl/trace_perm_unit.sv
module trace_perm_unit
  import trace_gate_pkg::*;
(
  input  priv_lvl_e level,
  input  logic      selfhost_en,
  input  logic      en_lvl0,
  input  logic      en_lvl1,
  input  logic      lvl2_active,
  input  logic      tge_route,
  input  logic      lvl2_trace_en,
  output logic      lvl0_routed,
  output logic      allow
);

  logic lvl0_ok;
  logic raw_ok;

  always_comb begin
    lvl0_routed = lvl2_active & tge_route;
    lvl0_ok     = lvl0_routed ? lvl2_trace_en : en_lvl0;
    unique case (level)
      PL_0:    raw_ok = lvl0_ok;
      PL_1:    raw_ok = en_lvl1;
      default: raw_ok = 1'b0;
    endcase
    allow = selfhost_en & raw_ok;
  end

endmodule

// File: rtl/trace_ts_select.sv
module trace_ts_select
  import trace_gate_pkg::*;
(
  input  logic     selfhost_en,
  input  logic     lvl2_present,
  input  ts_code_e l1_code,
  input  ts_code_e l2_code,
  output logic     code_from_l2,
  output ts_code_e eff_code,
  output logic     code_ok
);

  ts_code_e picked;

  always_comb begin
    code_from_l2 = lvl2_present && (l2_code != TS_NONE);
    picked       = code_from_l2 ? l2_code : l1_code;
    eff_code     = selfhost_en ? picked : TS_NONE;
    code_ok      = ts_code_usable(eff_code);
  end

endmodule

// File: rtl/trace_ts_reg.sv
module trace_ts_reg
  import trace_gate_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ts_code_e         code,
  input  logic             code_ok,
  input  logic [CNT_W-1:0] phys,
  input  logic [CNT_W-1:0] voff,
  output logic [CNT_W-1:0] ts_q,
  output logic             valid_q
);

  // Virtual time is the counter less the offset, wrapping at 2^CNT_W.
  function automatic logic [CNT_W-1:0] stamp_of(ts_code_e c,
                                                logic [CNT_W-1:0] p,
                                                logic [CNT_W-1:0] o);
    return (c == TS_VIRT) ? (p - o) : p;
  endfunction

  logic [CNT_W-1:0] stamp_d;

  always_comb stamp_d = stamp_of(code, phys, voff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= code_ok;
      if (code_ok) ts_q <= stamp_d;
    end
  end

endmodule

// File: rtl/trace_gate_ts.sv
module trace_gate_ts
  import trace_gate_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cur_level,
  input  logic             selfhost_en,
  input  logic             l1_en_lvl0,
  input  logic             l1_en_lvl1,
  input  logic [1:0]       l1_ts_code,
  input  logic             lvl2_present,
  input  logic             lvl2_active,
  input  logic             tge_route,
  input  logic             lvl2_trace_en,
  input  logic [1:0]       lvl2_ts_code,
  input  logic [CNT_W-1:0] phys_count,
  input  logic [CNT_W-1:0] virt_offset,
  output logic             trace_allowed,
  output logic [CNT_W-1:0] ts_value,
  output logic             ts_valid
);

  // Named internal events, visible to the bound checker.
  logic     lvl0_routed;
  logic     code_from_l2;
  ts_code_e eff_code;
  logic     ts_code_ok;

  trace_perm_unit u_perm (
    .level         (priv_lvl_e'(cur_level)),
    .selfhost_en   (selfhost_en),
    .en_lvl0       (l1_en_lvl0),
    .en_lvl1       (l1_en_lvl1),
    .lvl2_active   (lvl2_active),
    .tge_route     (tge_route),
    .lvl2_trace_en (lvl2_trace_en),
    .lvl0_routed   (lvl0_routed),
    .allow         (trace_allowed)
  );

  trace_ts_select u_sel (
    .selfhost_en  (selfhost_en),
    .lvl2_present (lvl2_present),
    .l1_code      (ts_code_e'(l1_ts_code)),
    .l2_code      (ts_code_e'(lvl2_ts_code)),
    .code_from_l2 (code_from_l2),
    .eff_code     (eff_code),
    .code_ok      (ts_code_ok)
  );

  trace_ts_reg #(.CNT_W(CNT_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (eff_code),
    .code_ok (ts_code_ok),
    .phys    (phys_count),
    .voff    (virt_offset),
    .ts_q    (ts_value),
    .valid_q (ts_valid)
  );

endmodule

// File: rtl/trace_gate_chk.sv
module trace_gate_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cur_level,
  input logic             selfhost_en,
  input logic             l1_en_lvl1,
  input logic             lvl2_present,
  input logic             lvl2_active,
  input logic             tge_route,
  input logic             lvl2_trace_en,
  input logic [1:0]       lvl2_ts_code,
  input logic [CNT_W-1:0] phys_count,
  input logic [CNT_W-1:0] virt_offset,
  input logic             trace_allowed,
  input logic [CNT_W-1:0] ts_value,
  input logic             ts_valid,
  input logic             lvl0_routed,
  input logic [1:0]       eff_code
);

  assert_high_levels_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level[1]) |-> !trace_allowed);

  assert_global_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!selfhost_en) |-> !trace_allowed);

  assert_global_off_stamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!selfhost_en) |=> !ts_valid);

  assert_lvl1_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (selfhost_en && cur_level == 2'd1) |-> (trace_allowed == l1_en_lvl1));

  assert_routed_lvl0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (selfhost_en && cur_level == 2'd0 && lvl2_active && tge_route)
      |-> (lvl0_routed && trace_allowed == lvl2_trace_en));

  assert_l2_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (selfhost_en && lvl2_present && lvl2_ts_code != 2'b00) |-> (eff_code == lvl2_ts_code));

  assert_phys_stamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_code == 2'b11) |=> (ts_valid && ts_value == $past(phys_count)));

  assert_virt_stamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_code == 2'b01) |=> (ts_valid && ts_value == $past(phys_count) - $past(virt_offset)));

  assert_hold_when_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts_valid) |-> $stable(ts_value));

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R10: assert (!ts_valid && ts_value == '0);
    end
  end

endmodule

bind trace_gate_ts trace_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cur_level     (cur_level),
  .selfhost_en   (selfhost_en),
  .l1_en_lvl1    (l1_en_lvl1),
  .lvl2_present  (lvl2_present),
  .lvl2_active   (lvl2_active),
  .tge_route     (tge_route),
  .lvl2_trace_en (lvl2_trace_en),
  .lvl2_ts_code  (lvl2_ts_code),
  .phys_count    (phys_count),
  .virt_offset   (virt_offset),
  .trace_allowed (trace_allowed),
  .ts_value      (ts_value),
  .ts_valid      (ts_valid),
  .lvl0_routed   (lvl0_routed),
  .eff_code      (eff_code)
);

// File: tb/sim_trace_gate_ts.sv
`timescale 1ns/100ps
module sim_trace_gate_ts;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cur_level = '0;
  logic        selfhost_en = 1'b0;
  logic        l1_en_lvl0 = 1'b0;
  logic        l1_en_lvl1 = 1'b0;
  logic [1:0]  l1_ts_code = '0;
  logic        lvl2_present = 1'b0;
  logic        lvl2_active = 1'b0;
  logic        tge_route = 1'b0;
  logic        lvl2_trace_en = 1'b0;
  logic [1:0]  lvl2_ts_code = '0;
  logic [63:0] phys_count = '0;
  logic [63:0] virt_offset = '0;
  logic        trace_allowed;
  logic [63:0] ts_value;
  logic        ts_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        v;
    logic [63:0] val;
    string       tag;
  } item_t;
  item_t       sb[$];
  logic [63:0] exp_hold = '0;

  always #2.5 clk = ~clk;

  trace_gate_ts u0 (.*);

  task automatic note(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus. The permission is checked in the same cycle;
  // the expected stamp is queued for the monitor.
  task automatic drive(input logic [1:0] lvl, input logic sh, input logic e1, input logic e0,
                       input logic l2p, input logic l2a, input logic tge, input logic l2e,
                       input logic [1:0] c1, input logic [1:0] c2,
                       input logic [63:0] ph, input logic [63:0] off, input string tag);
    logic       exp_allow;
    logic [1:0] code;
    item_t      it;
    @(negedge clk);
    cur_level = lvl; selfhost_en = sh; l1_en_lvl1 = e1; l1_en_lvl0 = e0;
    lvl2_present = l2p; lvl2_active = l2a; tge_route = tge; lvl2_trace_en = l2e;
    l1_ts_code = c1; lvl2_ts_code = c2; phys_count = ph; virt_offset = off;
    if (!sh || lvl >= 2) exp_allow = 1'b0;
    else if (lvl == 1) exp_allow = e1;
    else if (l2a && tge) exp_allow = l2e;
    else exp_allow = e0;
    if (!sh) code = 2'b00;
    else if (l2p && c2 != 2'b00) code = c2;
    else code = c1;
    it.tag = tag;
    it.v = (code == 2'b01) || (code == 2'b11);
    if (code == 2'b11) exp_hold = ph;
    else if (code == 2'b01) exp_hold = ph + (~off + 64'd1);
    it.val = exp_hold;
    sb.push_back(it);
    #1;
    note(trace_allowed == exp_allow, tag, "trace_allowed", {63'd0, trace_allowed}, {63'd0, exp_allow});
  endtask

  // Monitor: pops one item per edge and compares the registered stamp.
  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      note(ts_valid == it.v, it.tag, "ts_valid", {63'd0, ts_valid}, {63'd0, it.v});
      note(ts_value == it.val, it.tag, "ts_value", ts_value, it.val);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    note(ts_valid == 1'b0, "R10", "ts_valid in reset", {63'd0, ts_valid}, 64'd0);
    note(ts_value == 64'd0, "R10", "ts_value in reset", ts_value, 64'd0);
    rst_n = 1'b1;
    // global disable masks everything
    drive(2'd1, 0, 1, 1, 0, 0, 0, 1, 2'b11, 2'b00, 64'h55, 64'h0, "R2");
    drive(2'd0, 0, 1, 1, 1, 1, 1, 1, 2'b01, 2'b11, 64'h66, 64'h1, "R2");
    // level 1
    drive(2'd1, 1, 1, 0, 0, 0, 0, 0, 2'b11, 2'b00, 64'h1234_5678_9abc_def0, 64'h0, "R3");
    drive(2'd1, 1, 0, 1, 0, 0, 0, 1, 2'b11, 2'b00, 64'hffff_0000_ffff_0000, 64'h0, "R6");
    // level 0 direct
    drive(2'd0, 1, 0, 1, 0, 0, 0, 0, 2'b01, 2'b00, 64'd1000, 64'd10, "R4");
    drive(2'd0, 1, 1, 0, 0, 0, 0, 1, 2'b01, 2'b00, 64'd5, 64'd10, "R7");
    drive(2'd0, 1, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, 64'd7, 64'd1, "R4");
    // level 0 routed
    drive(2'd0, 1, 0, 0, 1, 1, 1, 1, 2'b10, 2'b00, 64'd9, 64'd1, "R5");
    drive(2'd0, 1, 1, 1, 1, 1, 1, 0, 2'b00, 2'b00, 64'd11, 64'd1, "R5");
    // levels 2 and 3
    drive(2'd2, 1, 1, 1, 0, 0, 0, 1, 2'b10, 2'b00, 64'd13, 64'd1, "R1");
    drive(2'd3, 1, 1, 1, 1, 1, 0, 1, 2'b00, 2'b00, 64'd15, 64'd1, "R1");
    // reserved codes hold a known stamp
    drive(2'd1, 1, 1, 1, 0, 0, 0, 0, 2'b11, 2'b00, 64'hdead_beef_0000_0001, 64'd0, "R6");
    drive(2'd1, 1, 1, 1, 0, 0, 0, 0, 2'b10, 2'b00, 64'd17, 64'd0, "R9");
    drive(2'd1, 1, 1, 1, 0, 0, 0, 0, 2'b00, 2'b00, 64'd19, 64'd0, "R9");
    // override by the level-2 code
    drive(2'd1, 1, 1, 1, 1, 0, 0, 0, 2'b01, 2'b11, 64'd500, 64'd100, "R8");
    drive(2'd1, 1, 1, 1, 0, 0, 0, 0, 2'b01, 2'b11, 64'd500, 64'd100, "R8");
    drive(2'd1, 1, 1, 1, 1, 0, 0, 0, 2'b11, 2'b00, 64'd777, 64'd100, "R8");
    drive(2'd1, 1, 1, 1, 1, 0, 0, 0, 2'b11, 2'b10, 64'd888, 64'd100, "R8");
    drive(2'd1, 1, 1, 1, 1, 0, 0, 0, 2'b11, 2'b01, 64'd3, 64'd4, "R7");
    drive(2'd1, 0, 1, 1, 1, 0, 0, 0, 2'b11, 2'b11, 64'd21, 64'd0, "R2");
    repeat (3) @(negedge clk);
    note(sb.size() == 0, "R6", "queue drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule